// File: doc/BRIEF.md
# Third-Order Cascaded Digital Noise-Shaping Modulator

This block sits between an interpolation filter and a unit-element DAC in an oversampled converter. It accepts one wide two's-complement sample per enabled clock. For each accepted sample it emits a short signed code whose quantization noise is pushed to high frequencies with third-order shaping. The downstream mismatch-shaping stage and the analog elements then turn that code into a level.

Three identical first-order error-feedback stages form a cascade. Each stage adds the error it kept from the previous accepted sample to its present input. It then splits the sum at bit position K: the bits above K become the stage output, which is a floor (arithmetic right shift). The bits below K remain as a non-negative residue. The first stage quantizes the sample itself. The second stage quantizes the first stage's residue, and the third stage quantizes the second stage's residue.

A cancellation network then merges the three stage outputs. It differentiates the second output once and the third output twice, using only adders and one left shift. This removes the first two stages' errors, so only the third-order-shaped error of the last stage reaches the output. The output width is derived from the input width and K so that the merged sum can never wrap.

Top module: `mash111_mod`

## Requirements
- R1: While `rst` is high at a rising edge, every residue and delay register clears, and after that edge `code_out` is 0 and `code_vld` is 0.
- R2: Stage one adds its held residue e1 to the sample and splits the sum s1 as q1 = floor(s1 / 2^K) and e1' = s1 - q1·2^K. The residue e1' therefore always lies in [0, 2^K).
- R3: Stage two quantizes e1' plus its own held residue, and stage three quantizes stage two's new residue plus its own held residue. Both use the same floor split, so their outputs q2 and q3 are each 0 or 1.
- R4: For each accepted sample n, `code_out` = q1[n] + q2[n] - q2[n-1] + q3[n] - 2·q3[n-1] + q3[n-2]. The indices n-1 and n-2 refer to earlier accepted samples, and all earlier terms are zero after reset.
- R5: A cycle with `smp_en` low leaves every residue, delay and `code_out` unchanged, whatever value `smp_in` carries in that cycle.
- R6: The code is signed with width W-K+3 (6 bits by default). Its value stays within ±(2^(W-K-1)+3), so full-scale inputs never overflow it.
- R7: For a constant input x held over N accepted samples, the sum of the N codes differs from N·x/2^K by less than 4.
- R8: `code_out` and `code_vld` change one clock after the accepted sample, and `code_vld` is high in exactly the cycle after each cycle with `smp_en` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| smp_en | input | 1 | Marks the current `smp_in` as an accepted sample |
| smp_in | input | W (24) | Two's-complement input sample |
| code_out | output | W-K+3 (6) | Signed multi-level modulator code |
| code_vld | output | 1 | High for one cycle after each accepted sample |

## Verification
The bench builds the block with its defaults, W = 24 and K = 21. Stage one then yields codes from -4 to +4 and the full code range spans ±7, so the extreme inputs of ±full scale can drive the cancellation sum to its widest values in a few thousand cycles. The small K-to-W gap also makes residue carries between stages frequent. Stages two and three therefore toggle often, and every term of the difference network is exercised. The long constant-input windows of R7 fit in the run for both signs of input.

// File: rtl/mash_pkg.sv
package mash_pkg;

    // Output code width: the first stage yields W-K+1 signed bits, and the
    // two differentiated correction terms add at most +/-3 on top.
    function automatic int code_width(input int w, input int k);
        return w - k + 3;
    endfunction

    // Width of the first stage's quantized output.
    function automatic int first_q_width(input int w, input int k);
        return w - k + 1;
    endfunction

endpackage

// File: rtl/mash_ef_stage.sv
module mash_ef_stage #(
    parameter int IW        = 24,
    parameter int K         = 21,
    parameter bit SIGNED_IN = 1'b1,
    localparam int AW       = IW + 1,
    localparam int QW       = AW - K
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          en,
    input  logic [IW-1:0] in_val,
    output logic [QW-1:0] q,
    output logic [K-1:0]  err
);

    logic [AW-1:0] ext_in;
    logic [AW-1:0] acc;
    logic [K-1:0]  err_q;

    generate
        if (SIGNED_IN) begin : g_sext
            assign ext_in = {in_val[IW-1], in_val};
        end else begin : g_zext
            assign ext_in = {1'b0, in_val};
        end
    endgenerate

    // The held residue is always non-negative, so it is zero-extended.
    assign acc = ext_in + {{(AW-K){1'b0}}, err_q};

    // A floor split: the upper bits are the arithmetic shift and the lower bits are the residue.
    assign q   = acc[AW-1:K];
    assign err = acc[K-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            err_q <= '0;
        end else if (en) begin
            err_q <= err;
        end
    end

    AST_STATE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !en |=> $stable(err_q)); // R5

    generate
        if (SIGNED_IN && (IW > K)) begin : g_qrange
            localparam logic signed [QW-1:0] QLIM = QW'(2 ** (QW - 2));
            AST_Q1_RANGE: assert property (@(posedge clk) disable iff (rst)
                en |-> ($signed(q) >= -QLIM && $signed(q) <= QLIM)); // R2
        end
    endgenerate

endmodule

// File: rtl/mash_cancel.sv
module mash_cancel #(
    parameter int Q1W = 4,
    parameter int OW  = 6,
    localparam int SW = OW + 2
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           en,
    input  logic [Q1W-1:0] q1,
    input  logic           q2,
    input  logic           q3,
    output logic [OW-1:0]  code,
    output logic           vld
);

    logic q2_d1;
    logic q3_d1;
    logic q3_d2;

    logic signed [SW-1:0] t_q1;
    logic signed [SW-1:0] t_q2;
    logic signed [SW-1:0] t_q2_d1;
    logic signed [SW-1:0] t_q3;
    logic signed [SW-1:0] t_q3_d1;
    logic signed [SW-1:0] t_q3_d2;
    logic signed [SW-1:0] sum;

    always_comb begin
        t_q1    = {{(SW-Q1W){q1[Q1W-1]}}, q1};
        t_q2    = {{(SW-1){1'b0}}, q2};
        t_q2_d1 = {{(SW-1){1'b0}}, q2_d1};
        t_q3    = {{(SW-1){1'b0}}, q3};
        t_q3_d1 = {{(SW-1){1'b0}}, q3_d1};
        t_q3_d2 = {{(SW-1){1'b0}}, q3_d2};
        // One difference on stage two and two differences on stage three; the gain of 2 is a shift.
        sum = t_q1 + (t_q2 - t_q2_d1) + (t_q3 - (t_q3_d1 <<< 1) + t_q3_d2);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q2_d1 <= 1'b0;
            q3_d1 <= 1'b0;
            q3_d2 <= 1'b0;
            code  <= '0;
            vld   <= 1'b0;
        end else begin
            vld <= en;
            if (en) begin
                q2_d1 <= q2;
                q3_d1 <= q3;
                q3_d2 <= q3_d1;
                code  <= sum[OW-1:0];
            end
        end
    end

    localparam logic signed [SW-1:0] SMIN = SW'(-(2 ** (OW - 1)));
    localparam logic signed [SW-1:0] SMAX = SW'((2 ** (OW - 1)) - 1);

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        en |-> (sum >= SMIN && sum <= SMAX)); // R6

    AST_CODE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !en |=> $stable(code)); // R5

    AST_VALID_TRACK: assert property (@(posedge clk) disable iff (rst)
        en |=> vld); // R8

    AST_VALID_QUIET: assert property (@(posedge clk) disable iff (rst)
        !en |=> !vld); // R8

endmodule

// File: rtl/mash111_mod.sv
module mash111_mod #(
    parameter int W  = 24,
    parameter int K  = 21,
    localparam int Q1W = mash_pkg::first_q_width(W, K),
    localparam int OW  = mash_pkg::code_width(W, K)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          smp_en,
    input  logic [W-1:0]  smp_in,
    output logic [OW-1:0] code_out,
    output logic          code_vld
);

    logic [Q1W-1:0] q1;
    logic [K-1:0]   e1;
    logic           q2;
    logic [K-1:0]   e2;
    logic           q3;
    logic [K-1:0]   e3;

    mash_ef_stage #(.IW(W), .K(K), .SIGNED_IN(1'b1)) u_st1 (
        .clk(clk), .rst(rst), .en(smp_en),
        .in_val(smp_in), .q(q1), .err(e1)
    );

    mash_ef_stage #(.IW(K), .K(K), .SIGNED_IN(1'b0)) u_st2 (
        .clk(clk), .rst(rst), .en(smp_en),
        .in_val(e1), .q(q2), .err(e2)
    );

    mash_ef_stage #(.IW(K), .K(K), .SIGNED_IN(1'b0)) u_st3 (
        .clk(clk), .rst(rst), .en(smp_en),
        .in_val(e2), .q(q3), .err(e3)
    );

    mash_cancel #(.Q1W(Q1W), .OW(OW)) u_cancel (
        .clk(clk), .rst(rst), .en(smp_en),
        .q1(q1), .q2(q2), .q3(q3),
        .code(code_out), .vld(code_vld)
    );

    // The last residue feeds no later stage.
    logic unused_e3;
    assign unused_e3 = ^e3;

    AST_RESET_CLEAR: assert property (@(posedge clk)
        rst |=> (code_out == '0 && !code_vld)); // R1

endmodule

// File: tb/mash111_mod_test.sv
`timescale 1ns/1ps
module mash111_mod_test;

    localparam int W  = 24;
    localparam int K  = 21;
    localparam int OW = W - K + 3;
    localparam longint SCALE = 64'sd1 << K;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          smp_en = 1'b0;
    logic [W-1:0]  smp_in = '0;
    logic [OW-1:0] code_out;
    logic          code_vld;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // Behavioural model state
    longint m_e1 = 0, m_e2 = 0, m_e3 = 0;
    longint m_q2p = 0, m_q3p = 0, m_q3pp = 0;
    longint m_y = 0;
    bit     m_v = 1'b0;

    always #4 clk = ~clk;

    mash111_mod uut (
        .clk(clk), .rst(rst), .smp_en(smp_en), .smp_in(smp_in),
        .code_out(code_out), .code_vld(code_vld)
    );

    function automatic longint got_code();
        return longint'($signed(code_out));
    endfunction

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic model_reset();
        m_e1 = 0; m_e2 = 0; m_e3 = 0;
        m_q2p = 0; m_q3p = 0; m_q3pp = 0;
        m_y = 0; m_v = 1'b0;
    endtask

    // Models one clock edge, drives the inputs, and checks the outputs at the following negedge.
    task automatic step(input bit en, input longint x);
        longint a, q1, q2, q3;
        smp_en = en;
        smp_in = W'(x);
        m_v = en;
        if (en) begin
            a  = x + m_e1;      q1 = a >>> K; m_e1 = a - q1 * SCALE;
            a  = m_e1 + m_e2;   q2 = a >>> K; m_e2 = a - q2 * SCALE;
            a  = m_e2 + m_e3;   q3 = a >>> K; m_e3 = a - q3 * SCALE;
            m_y = q1 + q2 - m_q2p + q3 - 2 * m_q3p + m_q3pp;
            m_q3pp = m_q3p; m_q3p = q3; m_q2p = q2;
        end
        @(negedge clk);
        // R2 R3 R4 R5: bit-exact comparison against the model
        chk(got_code() == m_y, "R4", got_code(), m_y);
        // R8: valid follows enable by one clock
        chk(code_vld == m_v, "R8", longint'(code_vld), longint'(m_v));
        // R6: code range bound
        chk(got_code() >= -7 && got_code() <= 7, "R6", got_code(), 7);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        smp_en = 1'b0;
        repeat (3) @(negedge clk);
        model_reset();
        // R1: cleared outputs under reset
        chk(code_out == '0, "R1", got_code(), 0);
        chk(code_vld == 1'b0, "R1", longint'(code_vld), 0);
        rst = 1'b0;
    endtask

    task automatic avg_window(input longint x, input int n);
        longint sum = 0, diff;
        for (int i = 0; i < n; i++) begin
            step(1'b1, x);
            sum += got_code();
        end
        diff = sum * SCALE - longint'(n) * x;
        if (diff < 0) diff = -diff;
        // R7: long-run average tracks x / 2^K
        chk(diff < 4 * SCALE, "R7", sum, (longint'(n) * x) / SCALE);
    endtask

    initial begin
        @(negedge clk);
        do_reset();

        // R1: the first sample after reset sees zero state (q1 = floor(x / 2^K))
        step(1'b1, 64'sd3 * SCALE + 5);
        chk(got_code() == 3 + 0, "R1", got_code(), 3);

        // Zero input
        for (int i = 0; i < 20; i++) step(1'b1, 0);

        // Full-scale extremes, pushing toward the widest code (R6)
        for (int i = 0; i < 300; i++) step(1'b1, (64'sd1 << (W - 1)) - 1);
        for (int i = 0; i < 300; i++) step(1'b1, -(64'sd1 << (W - 1)));
        for (int i = 0; i < 200; i++) step(1'b1, (i % 2 == 0) ? ((64'sd1 << (W - 1)) - 1) : -(64'sd1 << (W - 1)));

        // Random samples with random enable gaps; idle cycles carry garbage (R5)
        for (int i = 0; i < 3000; i++) begin
            longint x;
            bit en;
            x  = longint'($signed(W'($urandom)));
            en = ($urandom % 4) != 0;
            step(en, x);
        end

        // R5: a long idle stretch with changing input holds code and state
        step(1'b1, 64'sd1234567);
        for (int i = 0; i < 30; i++) step(1'b0, longint'($signed(W'($urandom))));
        for (int i = 0; i < 10; i++) step(1'b1, 64'sd1234567);

        // R7: constant-input averages, both signs
        avg_window(64'sd5000001, 4096);
        avg_window(-64'sd6543210, 4096);

        // R1: reset in mid-run clears history
        do_reset();
        step(1'b1, -64'sd1);
        chk(got_code() == -1, "R1", got_code(), -1);
        for (int i = 0; i < 50; i++) step(1'b1, 64'sd777777);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual %0d expected %0d", 0, 1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule